// File: doc/BRIEF.md
# Integer Divider with Divide-Error Trap

This block is a multi-cycle integer divider for a 16-bit accumulator datapath. It has two operating modes. In word mode it takes a signed 32-bit dividend, built from a high word and a low word, and divides it by a signed 16-bit divisor. It produces a 16-bit quotient and a 16-bit remainder. In byte mode it divides the 16-bit low word, taken as unsigned, by the unsigned low byte of the divisor. It then packs the 8-bit quotient and the 8-bit remainder into one 16-bit word. Signed results truncate toward zero, and the remainder carries the sign of the dividend.

Some operands have no representable result: a zero divisor, a word-mode dividend of 0x80000000, or a quotient too wide for its destination. For these the block raises a divide-error trap request in place of a result, and it leaves the result registers untouched. The core is a radix-2 shift-subtract engine that works on magnitudes. The state machine has four states:

- IDLE waits for `start`. When a trap is found up front it goes to REPORT; otherwise it goes to RUN.
- RUN performs one quotient bit per cycle. It goes to FIX after the last iteration.
- FIX applies the signs and the range check, then always goes to REPORT.
- REPORT raises `done` for one cycle, then always returns to IDLE.

Top module: `divtrap_unit`

## Requirements
- R1: In word mode (`byte_mode`=0) the dividend {`acc_hi`,`acc_lo`} and the `divisor` are two's-complement signed. On success `res_lo` holds the quotient truncated toward zero, and `res_hi` holds the remainder, which has the sign of the dividend.
- R2: In byte mode (`byte_mode`=1) `acc_lo` is divided, unsigned, by `divisor[7:0]`. The upper divisor byte is ignored. On success `res_lo[7:0]` holds the quotient, `res_lo[15:8]` holds the remainder, and `res_hi` equals the `acc_hi` value captured at start.
- R3: A zero divisor raises `trap`. In word mode that means all 16 bits are zero; in byte mode it means the low 8 bits are zero. On a trap `res_lo` and `res_hi` keep their previous values.
- R4: In word mode a dividend of 0x80000000 raises `trap` for any divisor.
- R5: In word mode a quotient outside -32768..32767 raises `trap`, and the results are unchanged.
- R6: In byte mode a quotient above 0xFF raises `trap`, and the results are unchanged.
- R7: Let the edge that samples `start` in IDLE count as edge 1. An R3 or R4 trap shows `done` after edge 1. Otherwise `done` shows after edge 34 in word mode and after edge 18 in byte mode.
- R8: `done` is high for exactly one cycle. `trap` is high only together with `done`. `wr_en` equals `done` without `trap`.
- R9: A `start` raised while the unit is busy is ignored, and the running operation completes with its own operands.
- R10: After reset, `busy`, `done`, `trap`, `wr_en`, `res_lo` and `res_hi` are all zero. `busy` is high from the cycle after acceptance through the `done` cycle, and it is low in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a division; taken only in IDLE |
| byte_mode | input | 1 | 1 selects unsigned 16/8 division, 0 selects signed 32/16 |
| acc_hi | input | 16 | High dividend word (word mode) or word passed through to `res_hi` (byte mode) |
| acc_lo | input | 16 | Low dividend word, or the whole dividend in byte mode |
| divisor | input | 16 | Divisor; only bits 7:0 are used in byte mode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| trap | output | 1 | Divide-error trap request, valid with `done` |
| wr_en | output | 1 | Result write enable, valid with `done` |
| res_lo | output | 16 | Quotient (word mode) or {remainder, quotient} (byte mode) |
| res_hi | output | 16 | Remainder (word mode) or captured `acc_hi` (byte mode) |

## Verification
An early trap shows `done` one edge after acceptance. A full division takes 34 edges in word mode and 18 in byte mode. These counts come from the two iteration counts plus one FIX cycle and one acceptance edge. The bench drives inputs on falling edges and counts rising edges from acceptance until it samples `done` on a falling edge. It compares that count against the latency it expects for the operand class. Results, `trap` and `wr_en` are sampled in that same `done` cycle, and `busy` and `done` are checked again one edge later.

// File: rtl/divtrap_pkg.sv
package divtrap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIX,
        ST_REPORT
    } div_state_e;

endpackage

// File: rtl/divtrap_precheck.sv
// Operand conditioning: magnitudes, result signs and up-front trap detection.
module divtrap_precheck #(
    parameter int W = 16
) (
    input  logic              byte_mode,
    input  logic [W-1:0]      hi,
    input  logic [W-1:0]      lo,
    input  logic [W-1:0]      dsr,
    output logic [2*W-1:0]    dvd_mag,
    output logic [W-1:0]      dsr_mag,
    output logic              q_neg,
    output logic              r_neg,
    output logic              early_trap
);
    localparam int DW = 2 * W;
    localparam int HW = W / 2;

    logic [DW-1:0] dvd;
    logic          dvd_s;
    logic          dsr_s;

    assign dvd   = {hi, lo};
    assign dvd_s = dvd[DW-1];
    assign dsr_s = dsr[W-1];

    always_comb begin
        if (byte_mode) begin
            // dividend left-justified so W iterations consume it
            dvd_mag    = {lo, {W{1'b0}}};
            dsr_mag    = {{(W-HW){1'b0}}, dsr[HW-1:0]};
            q_neg      = 1'b0;
            r_neg      = 1'b0;
            early_trap = (dsr[HW-1:0] == '0);
        end else begin
            dvd_mag    = dvd_s ? -dvd : dvd;
            dsr_mag    = dsr_s ? -dsr : dsr;
            q_neg      = dvd_s ^ dsr_s;
            r_neg      = dvd_s;
            early_trap = (dsr == '0) || (dvd == {1'b1, {(DW-1){1'b0}}});
        end
    end

endmodule

// File: rtl/divtrap_step.sv
// One radix-2 restoring shift-subtract iteration on magnitudes.
module divtrap_step #(
    parameter int W = 16
) (
    input  logic [W-1:0]   rem_in,
    input  logic [2*W-1:0] quo_in,
    input  logic [W-1:0]   dsr,
    output logic [W-1:0]   rem_out,
    output logic [2*W-1:0] quo_out
);
    localparam int DW = 2 * W;

    logic [W:0] shifted;
    logic [W:0] diff;
    logic       fits;

    assign shifted = {rem_in, quo_in[DW-1]};
    assign diff    = shifted - {1'b0, dsr};
    assign fits    = ~diff[W];
    assign rem_out = fits ? diff[W-1:0] : shifted[W-1:0];
    assign quo_out = {quo_in[DW-2:0], fits};

endmodule

// File: rtl/divtrap_fixup.sv
// Sign restoration, range check and packing of the final result.
module divtrap_fixup #(
    parameter int W = 16
) (
    input  logic           byte_mode,
    input  logic [2*W-1:0] quo,
    input  logic [W-1:0]   rem,
    input  logic           q_neg,
    input  logic           r_neg,
    input  logic [W-1:0]   hi_keep,
    output logic [W-1:0]   lo_out,
    output logic [W-1:0]   hi_out,
    output logic           ovf
);
    localparam int DW = 2 * W;
    localparam int HW = W / 2;

    logic [W-1:0] qv;
    logic         ovf_pos;
    logic         ovf_neg;

    assign qv      = quo[W-1:0];
    assign ovf_pos = |quo[DW-1:W-1];
    assign ovf_neg = (|quo[DW-1:W]) || (quo[W-1] && (|quo[W-2:0]));

    always_comb begin
        if (byte_mode) begin
            ovf    = |quo[W-1:HW];
            lo_out = {rem[HW-1:0], quo[HW-1:0]};
            hi_out = hi_keep;
        end else begin
            ovf    = q_neg ? ovf_neg : ovf_pos;
            lo_out = q_neg ? -qv : qv;
            hi_out = r_neg ? -rem : rem;
        end
    end

endmodule

// File: rtl/divtrap_unit.sv
module divtrap_unit #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         byte_mode,
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic         trap,
    output logic         wr_en,
    output logic [W-1:0] res_lo,
    output logic [W-1:0] res_hi
);
    import divtrap_pkg::*;

    localparam int DW = 2 * W;
    localparam int CW = $clog2(DW + 1);

    div_state_e state_q, state_d;

    logic [DW-1:0] pc_dvd;
    logic [W-1:0]  pc_dsr;
    logic          pc_qneg, pc_rneg, pc_trap;

    logic          mode_q, qneg_q, rneg_q, trap_q;
    logic [W-1:0]  hi_q, rem_q, dsr_q, res_lo_q, res_hi_q;
    logic [DW-1:0] quo_q;
    logic [CW-1:0] cnt_q;

    logic [W-1:0]  st_rem;
    logic [DW-1:0] st_quo;
    logic [W-1:0]  fx_lo, fx_hi;
    logic          fx_ovf;
    logic          accept;

    divtrap_precheck #(.W(W)) u_pre (
        .byte_mode (byte_mode),
        .hi        (acc_hi),
        .lo        (acc_lo),
        .dsr       (divisor),
        .dvd_mag   (pc_dvd),
        .dsr_mag   (pc_dsr),
        .q_neg     (pc_qneg),
        .r_neg     (pc_rneg),
        .early_trap(pc_trap)
    );

    divtrap_step #(.W(W)) u_step (
        .rem_in (rem_q),
        .quo_in (quo_q),
        .dsr    (dsr_q),
        .rem_out(st_rem),
        .quo_out(st_quo)
    );

    divtrap_fixup #(.W(W)) u_fix (
        .byte_mode(mode_q),
        .quo      (quo_q),
        .rem      (rem_q),
        .q_neg    (qneg_q),
        .r_neg    (rneg_q),
        .hi_keep  (hi_q),
        .lo_out   (fx_lo),
        .hi_out   (fx_hi),
        .ovf      (fx_ovf)
    );

    assign accept = (state_q == ST_IDLE) && start;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = pc_trap ? ST_REPORT : ST_RUN;
            ST_RUN:    if (cnt_q == CW'(1)) state_d = ST_FIX;
            ST_FIX:    state_d = ST_REPORT;
            ST_REPORT: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= 1'b0;
            qneg_q   <= 1'b0;
            rneg_q   <= 1'b0;
            trap_q   <= 1'b0;
            hi_q     <= '0;
            rem_q    <= '0;
            dsr_q    <= '0;
            quo_q    <= '0;
            cnt_q    <= '0;
            res_lo_q <= '0;
            res_hi_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        mode_q <= byte_mode;
                        hi_q   <= acc_hi;
                        qneg_q <= pc_qneg;
                        rneg_q <= pc_rneg;
                        rem_q  <= '0;
                        quo_q  <= pc_dvd;
                        dsr_q  <= pc_dsr;
                        cnt_q  <= byte_mode ? CW'(W) : CW'(DW);
                        trap_q <= pc_trap;
                    end
                end
                ST_RUN: begin
                    rem_q <= st_rem;
                    quo_q <= st_quo;
                    cnt_q <= cnt_q - CW'(1);
                end
                ST_FIX: begin
                    trap_q <= fx_ovf;
                    if (!fx_ovf) begin
                        res_lo_q <= fx_lo;
                        res_hi_q <= fx_hi;
                    end
                end
                ST_REPORT: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy   = (state_q != ST_IDLE);
        done   = (state_q == ST_REPORT);
        trap   = done && trap_q;
        wr_en  = done && !trap_q;
        res_lo = res_lo_q;
        res_hi = res_hi_q;
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // covers R3 and R4: up-front trap answers in the very next cycle
    assert_early_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pc_trap) |=> (done && trap));

    assert_zero_divisor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !byte_mode && divisor == '0) |=> trap);

    assert_min_dividend_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !byte_mode && {acc_hi, acc_lo} == {1'b1, {(DW-1){1'b0}}}) |=> trap);

    assert_trap_keeps_results_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && trap) |-> ($stable(res_lo) && $stable(res_hi)));

    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && start) |=> ($stable(dsr_q) && $stable(mode_q)));

endmodule

// File: tb/tb_divtrap_unit.sv
module tb_divtrap_unit;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         byte_mode = 1'b0;
    logic [W-1:0] acc_hi = '0;
    logic [W-1:0] acc_lo = '0;
    logic [W-1:0] divisor = '0;
    logic         busy, done, trap, wr_en;
    logic [W-1:0] res_lo, res_hi;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    divtrap_unit #(.W(W)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_mode(byte_mode),
        .acc_hi(acc_hi), .acc_lo(acc_lo), .divisor(divisor),
        .busy(busy), .done(done), .trap(trap), .wr_en(wr_en),
        .res_lo(res_lo), .res_hi(res_hi)
    );

    task automatic check(string req, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(bit bm, logic [15:0] hi, logic [15:0] lo, logic [15:0] dsr, bit poke);
        logic signed [31:0] s32;
        logic signed [15:0] s16;
        longint dv, dd, q, r;
        bit     exp_trap;
        int     exp_lat;
        int     lat;
        string  req;
        logic [15:0] exp_lo, exp_hi, prev_lo, prev_hi;

        prev_lo = res_lo;
        prev_hi = res_hi;
        exp_lo = prev_lo;
        exp_hi = prev_hi;
        if (!bm) begin
            s32 = {hi, lo};
            s16 = dsr;
            dv = s32;
            dd = s16;
            if (dd == 0) begin
                exp_trap = 1; exp_lat = 1; req = "R3";
            end else if (dv == -64'sd2147483648) begin
                exp_trap = 1; exp_lat = 1; req = "R4";
            end else begin
                q = dv / dd;
                r = dv % dd;
                exp_lat = 34;
                if (q > 32767 || q < -32768) begin
                    exp_trap = 1; req = "R5";
                end else begin
                    exp_trap = 0; req = "R1";
                    exp_lo = q[15:0];
                    exp_hi = r[15:0];
                end
            end
        end else begin
            dv = lo;
            dd = dsr[7:0];
            if (dd == 0) begin
                exp_trap = 1; exp_lat = 1; req = "R3";
            end else begin
                q = dv / dd;
                r = dv % dd;
                exp_lat = 18;
                if (q > 255) begin
                    exp_trap = 1; req = "R6";
                end else begin
                    exp_trap = 0; req = "R2";
                    exp_lo = {r[7:0], q[7:0]};
                    exp_hi = hi;
                end
            end
        end

        @(negedge clk);
        byte_mode = bm; acc_hi = hi; acc_lo = lo; divisor = dsr; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
            if (poke) begin
                // R9: a second request mid-run with other operands
                if (lat == 5) begin
                    start = 1'b1; divisor = ~dsr; acc_lo = ~lo; byte_mode = ~bm;
                end else begin
                    start = 1'b0;
                end
            end
        end
        start = 1'b0;
        check(poke ? "R9" : "R7", "latency", lat, exp_lat);
        check(req, "trap", trap, exp_trap);
        check("R8", "wr_en", wr_en, !exp_trap);
        check(poke ? "R9" : req, "res_lo", res_lo, exp_lo);
        check(poke ? "R9" : req, "res_hi", res_hi, exp_hi);
        check("R10", "busy in done cycle", busy, 1);
        @(posedge clk);
        @(negedge clk);
        check("R8", "done after pulse", done, 0);
        check("R10", "busy after done", busy, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] wd [19] = '{32'd0, 32'd1, 32'hFFFFFFFF, 32'd7, 32'hFFFFFFF9,
                                 32'd100000, -32'sd100000, 32'h7FFFFFFF, 32'h80000000,
                                 32'h80000001, 32'd98301, -32'sd65536, 32'h00007FFF,
                                 32'h00008000, -32'sd32768, 32'h12345678, -32'sh12345678,
                                 32'd65535, 32'd1000000};
        logic [15:0] ws [18] = '{16'd0, 16'd1, 16'hFFFF, 16'd2, 16'hFFFE, 16'd3, 16'hFFFD,
                                 16'd7, 16'hFFF9, 16'd100, 16'hFF9C, 16'd255, 16'hFF00,
                                 16'h7FFF, 16'h8000, 16'h7000, 16'hEDCC, 16'd12345};
        logic [15:0] bd [11] = '{16'd0, 16'd1, 16'd2, 16'h7F, 16'hFF, 16'h100, 16'h1FE,
                                 16'h1FF, 16'h7FFF, 16'h8000, 16'hFFFF};

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset values
        check("R10", "busy at reset", busy, 0);
        check("R10", "done at reset", done, 0);
        check("R10", "trap at reset", trap, 0);
        check("R10", "wr_en at reset", wr_en, 0);
        check("R10", "res_lo at reset", res_lo, 0);
        check("R10", "res_hi at reset", res_hi, 0);
        rst_n = 1'b1;

        // word-mode sweep: R1 R3 R4 R5 R7
        foreach (wd[i]) begin
            foreach (ws[j]) begin
                run_op(1'b0, wd[i][31:16], wd[i][15:0], ws[j], 1'b0);
            end
        end

        // byte-mode sweep: R2 R3 R6 R7, junk in divisor upper byte and acc_hi
        for (int i = 0; i < 23; i++) begin
            logic [15:0] a;
            a = (i < 11) ? bd[i] : 16'((i - 11) * 16'h0B3D);
            for (int d = 0; d < 256; d += 3) begin
                run_op(1'b1, 16'hA5A5 ^ 16'(i), a, {8'(d * 7 + i), 8'(d)}, 1'b0);
            end
            run_op(1'b1, 16'h5A5A, a, 16'hC3FF, 1'b0);
            run_op(1'b1, 16'h0F0F, a, 16'h3C02, 1'b0);
        end

        // R9: start while busy is ignored
        run_op(1'b0, 16'h0001, 16'h2345, 16'd97, 1'b1);
        run_op(1'b0, 16'hFFFE, 16'h1234, 16'hFF85, 1'b1);
        run_op(1'b1, 16'h1111, 16'hBEEF, 16'h0033, 1'b1);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule